// File: doc/BRIEF.md
# Serial ADC frame capture controller

This block runs the host side of a three-wire link to an external 12-bit successive-approximation converter. A start pulse, or a free-running request, pulls chip select low. That falling edge is the moment the converter samples its input. The block then produces sixteen serial clock periods, whose speed a divider parameter sets. It samples the converter's data line on each rising edge and shifts the bits into a 16-bit word.

In each frame the first bit is a zero. The 12 result bits follow, MSB first, then two zero pad bits and a final bit during which the converter releases its line. At the end of the frame the block returns chip select high and pulses a valid strobe with the 12-bit result. It raises an error flag if any of the three pad bits read as one. With a request waiting, the next frame follows after a single high clock of chip select, which gives full throughput. Without one, the link stays idle for as long as needed.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, chip select and serial clock are high, busy is low and valid is low.
- R2: A start pulse in idle drives chip select low on the next system clock edge. Busy stays high for as long as chip select is low.
- R3: Each serial clock phase lasts DIV_HALF system clocks. A frame has exactly 16 rising serial clock edges, so chip select stays low for 32*DIV_HALF clocks. The serial clock is high whenever chip select is high.
- R4: Each rising serial clock edge captures one data bit. The first capture lands in word bit 15 and the last in bit 0. The result is word bits 14 down to 3, so the bit captured on the 2nd rising edge becomes the result MSB and the 13th becomes the LSB.
- R5: Valid is a one-cycle pulse in the cycle chip select returns high. The result and error outputs change only with valid and hold their values until the next valid.
- R6: The error flag is set when word bit 15, 2 or 1 is one. Word bit 0, the 16th capture, affects neither the result nor the flag.
- R7: A start that arrives while a frame runs is served right after it, and chip select is high for exactly one system clock between the two frames.
- R8: While free-run is held high, frames follow each other back to back with one clock of chip select high between them.
- R9: Several start pulses during one frame produce only one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request for a conversion frame |
| free_run_i | input | 1 | Start frames continuously while high |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame in progress |
| sample_o | output | 12 | Latest conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Pad bits of the latest frame were not zero |

## Verification
A bit counter that is off by one changes the chip-select low time by 2*DIV_HALF clocks. It also shifts every result bit by one place, and the error flag fires on correct zero padding. Both show at the first valid strobe, one frame after start. A lost or stuck pending request shows as a missing second valid, or as a chip-select gap wider than one clock, within two frame times. A wrong divider shows in the chip-select low time of the first frame.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int FRAME_LEN = 16;
  localparam int RES_W     = 12;
  localparam int RES_HI    = FRAME_LEN - 2;
  localparam int RES_LO    = RES_HI - RES_W + 1;

  typedef logic [FRAME_LEN-1:0] frame_word_t;
  typedef logic [RES_W-1:0]     sample_t;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  function automatic sample_t frame_sample(frame_word_t w);
    return w[RES_HI:RES_LO];
  endfunction

  function automatic logic frame_pad_err(frame_word_t w);
    return w[FRAME_LEN-1] | (|w[RES_LO-1:1]);
  endfunction
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic free_run_i,
  input  logic tick_i,
  output logic run_o,
  output logic cs_n_o,
  output logic sclk_o,
  output logic rise_o,
  output logic last_o
);
  localparam int BCW = $clog2(FRAME_LEN + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_LEN - 1);

  seq_state_t     state_q;
  logic           pend_q;
  logic           sclk_q;
  logic           cs_n_q;
  logic [BCW-1:0] bit_q;

  assign run_o  = (state_q == ST_RUN);
  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign rise_o = run_o && tick_i && !sclk_q;
  assign last_o = rise_o && (bit_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      sclk_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      bit_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i || pend_q || free_run_i) begin
            state_q <= ST_RUN;
            cs_n_q  <= 1'b0;
            pend_q  <= 1'b0;
            bit_q   <= '0;
          end
        end
        default: begin
          if (start_i) pend_q <= 1'b1;
          if (tick_i)  sclk_q <= ~sclk_q;
          if (rise_o)  bit_q  <= bit_q + 1'b1;
          if (last_o) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_shift_cap.sv
module adc_shift_cap
  import adc_frame_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sdi_i,
  input  logic    rise_i,
  input  logic    last_i,
  output sample_t sample_o,
  output logic    err_o,
  output logic    valid_o
);
  frame_word_t shreg_q;
  frame_word_t word_nxt;
  sample_t     sample_q;
  logic        err_q;
  logic        valid_q;

  assign word_nxt = {shreg_q[FRAME_LEN-2:0], sdi_i};
  assign sample_o = sample_q;
  assign err_o    = err_q;
  assign valid_o  = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      sample_q <= '0;
      err_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= last_i;
      if (rise_i) shreg_q <= word_nxt;
      if (last_i) begin
        sample_q <= frame_sample(word_nxt);
        err_q    <= frame_pad_err(word_nxt);
      end
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             free_run_i,
  input  logic             sdi_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic [RES_W-1:0] sample_o,
  output logic             valid_o,
  output logic             frame_err_o
);
  logic run_w;
  logic tick_w;
  logic rise_w;
  logic last_w;

  assign busy_o = run_w;

  adc_sclk_div #(.DIV_HALF(DIV_HALF)) div_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .tick_o(tick_w)
  );

  adc_frame_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
    .tick_i(tick_w), .run_o(run_w), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .rise_o(rise_w), .last_o(last_w)
  );

  adc_shift_cap cap_i (
    .clk(clk), .rst_n(rst_n), .sdi_i(sdi_i), .rise_i(rise_w), .last_i(last_w),
    .sample_o(sample_o), .err_o(frame_err_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk #(
  parameter int FRAME_LEN = 16,
  parameter int RES_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [RES_W-1:0] sample_o,
  input logic             rise_w,
  input logic             last_w
);
  logic       sclk_d, cs_d;
  logic [7:0] rise_cnt;
  logic       sclk_up, cs_down;

  assign sclk_up = sclk_o & ~sclk_d;
  assign cs_down = ~cs_n_o & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      cs_d     <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_n_o;
      if (cs_down)      rise_cnt <= '0;
      else if (sclk_up) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);
  assert_busy_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);
  assert_rise_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((rise_cnt + 8'(sclk_up)) == 8'(FRAME_LEN)));
  assert_rise_drives_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> (sclk_o && !$past(sclk_o)));
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_at_cs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (valid_o && cs_n_o));
  assert_sample_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> (valid_o || $stable(sample_o)));
endmodule

bind adc_frame_ctrl adc_frame_chk #(
  .FRAME_LEN(adc_frame_pkg::FRAME_LEN),
  .RES_W(adc_frame_pkg::RES_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .valid_o(valid_o), .sample_o(sample_o),
  .rise_w(rise_w), .last_w(last_w)
);

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
  localparam int DIV   = 2;
  localparam int LOW_T = 32 * DIV;
  localparam int NV    = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h7FF8, 16'h7FF9, 16'hAAA8,
    16'h4004, 16'h0012, 16'h1238, 16'h5555
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, free_run = 1'b0, sdi = 1'b1;
  logic cs_n, sclk, busy, valid, ferr;
  logic [11:0] sample;

  int n_chk = 0, n_fail = 0;
  logic [15:0] q [64];
  int qi = 0, ci = 0, k = 0;
  logic [15:0] cur_word = '0;
  logic [11:0] last_exp = '0;
  int hi_run = 0, lo_run = 0, last_gap = 0, last_low = 0;

  always #4 clk = ~clk;

  adc_frame_ctrl #(.DIV_HALF(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .free_run_i(free_run),
    .sdi_i(sdi), .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy),
    .sample_o(sample), .valid_o(valid), .frame_err_o(ferr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: launches word bits on serial clock falling edges
  always @(negedge cs_n) begin
    cur_word = q[qi];
    qi++;
    k = 0;
  end
  always @(negedge sclk) begin
    if (!cs_n && k < 16) begin
      sdi = cur_word[15 - k];
      k++;
    end
  end

  // result monitor, expected values restated from the frame word
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) begin
        if (lo_run > 0) last_low = lo_run;
        lo_run = 0;
        hi_run++;
      end else begin
        if (hi_run > 0) last_gap = hi_run;
        hi_run = 0;
        lo_run++;
      end
      if (valid) begin
        logic [15:0] w;
        logic [11:0] es;
        logic        ee;
        w  = q[ci];
        es = 12'((w >> 3) & 16'h0FFF);
        ee = (w[15] == 1'b1) || (w[2] == 1'b1) || (w[1] == 1'b1);
        check(sample == es, "R4 result", int'(sample), int'(es));
        check(ferr == ee, "R6 pad error", int'(ferr), int'(ee));
        check(cs_n == 1'b1, "R5 valid with cs high", int'(cs_n), 1);
        last_exp = es;
        ci++;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 1000 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      q[i] = (i < NV) ? VEC[i] : 16'(((i * 733) & 16'h0FFF) << 3) | 16'(i & 1);
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1, "R1 idle pins", int'({cs_n, sclk}), 3);
    check(busy == 1'b0 && valid == 1'b0, "R1 idle status", int'({busy, valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (v == 0) check(cs_n == 1'b0 && busy == 1'b1, "R2 cs falls next clock",
                        int'({cs_n, busy}), 1);
      wait_idle();
      if (v == 0) check(last_low == LOW_T, "R3 cs low time", last_low, LOW_T);
      repeat (5) @(negedge clk);
      check(valid == 1'b0 && sample == last_exp, "R5 result held",
            int'(sample), int'(last_exp));
    end
    check(ci == NV, "R4 frame count", ci, NV);

    // R7 / R9: starts during a frame are merged into one pending frame
    begin
      int base;
      base = ci;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();
      repeat (3) @(negedge clk);
      pulse_start();
      repeat (3 * (LOW_T + 4)) @(negedge clk);
      check(ci - base == 2, "R9 one extra frame", ci - base, 2);
      check(last_gap == 1, "R7 back-to-back gap", last_gap, 1);
    end

    // R8: free-running frames
    begin
      int base;
      base = ci;
      @(negedge clk) free_run = 1'b1;
      repeat (4 * (LOW_T + 1)) @(negedge clk);
      free_run = 1'b0;
      check(last_gap == 1, "R8 free-run gap", last_gap, 1);
      wait_idle();
      check(ci - base >= 4, "R8 free-run frames", ci - base, 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule